// File: doc/BRIEF.md
# Masked Identifier Acceptance Filter with Receive Queue

This block screens received CAN messages before they reach host software. It holds a bank of programmable acceptance filters, each paired with its own mask. For every valid message it compares a 45-bit key (the 29-bit identifier followed by the first two data bytes) and the frame-format flag against all filters in parallel. A message is stored only when at least one filter accepts it. A global enable lets the bank be switched off, and then every valid message is stored.

Accepted messages go into a small first-in first-out queue together with a code that names the filter that accepted them. The host reads the oldest entry from the head outputs and removes it with a pop strobe. A message that is accepted while the queue is full is lost, and a sticky flag records the loss. Frame reception, bit timing and CRC checking take place upstream of this block.

Top module: `canAcceptBank`

## Requirements
- R1: After reset the queue is empty (fifoEmpty=1, fifoCount=0, fifoFull=0), overflowFlag=0 and pushStrobe=0. All filter and mask registers reset to zero.
- R2: A configuration write (cfgWrite=1) loads the register of filter cfgSel. When cfgIsMask=0 it loads the filter word, laid out as bit 45 = format flag, bits 44:16 = identifier, bits 15:8 = first data byte, bits 7:0 = second data byte. When cfgIsMask=1 it loads the mask from bits 44:0 in the same layout. A key bit whose mask bit is 1 must equal the filter bit. A key bit whose mask bit is 0 is ignored.
- R3: A filter matches only when msgIde equals its format flag, whatever the mask. A standard message (msgIde=0) is compared with msgId[10:0] placed in key identifier bits 28:18 and with zeros in identifier bits 17:0. Bits 28:11 of msgId are ignored for such a message.
- R4: With filtEnable=0 every valid message is stored, and its hit code is 0000.
- R5: With filtEnable=1, a message that matches no filter is discarded. No push occurs and fifoCount does not change.
- R6: With filtEnable=1 the hit code is binary 1000 plus the number of the matching filter (filter 0 gives 1000, filter 7 gives 1111). When several filters match, the lowest-numbered one is reported.
- R7: The queue holds 8 messages and returns them oldest first. The head outputs give the stored msgId (as presented), format flag, both data bytes and the hit code. A pop (popReq=1) removes the head.
- R8: A message that passes while the queue holds 8 entries is dropped, even when a pop occurs in the same cycle, and overflowFlag is set. Only reset clears overflowFlag.
- R9: An accepted message is stored exactly once. pushStrobe is high for one cycle, in the cycle after msgValid, and hitCode holds that message's hit code.
- R10: A pop while the queue is empty is ignored, and the queue stays empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| msgValid | input | 1 | One-cycle strobe: a received message is presented |
| msgId | input | 29 | Identifier; a standard identifier uses bits 10:0 |
| msgIde | input | 1 | 1 = extended identifier, 0 = standard |
| msgData0 | input | 8 | First data byte |
| msgData1 | input | 8 | Second data byte |
| filtEnable | input | 1 | 1 = filtering on, 0 = accept all |
| cfgWrite | input | 1 | Write strobe for a filter or mask register |
| cfgSel | input | 3 | Filter number to write |
| cfgIsMask | input | 1 | 1 = write the mask, 0 = write the filter |
| cfgValue | input | 46 | Filter or mask word |
| popReq | input | 1 | Remove the head entry |
| pushStrobe | output | 1 | A message was stored on the previous edge |
| hitCode | output | 4 | Hit code of the last stored message |
| fifoCount | output | 4 | Number of stored messages |
| fifoFull | output | 1 | Queue holds 8 messages |
| fifoEmpty | output | 1 | Queue holds no message |
| overflowFlag | output | 1 | Sticky: an accepted message was lost |
| rdId | output | 29 | Head entry identifier |
| rdIde | output | 1 | Head entry format flag |
| rdData0 | output | 8 | Head entry first data byte |
| rdData1 | output | 8 | Head entry second data byte |
| rdHit | output | 4 | Head entry hit code |

## Verification
The properties assume that msgValid, popReq and cfgWrite are single-cycle, synchronous strobes. They also assume that filtEnable is steady during the cycle in which a message is presented, because the acceptance decision and the reported code both depend on it. The stimulus changes every input only at the falling clock edge and holds filtEnable constant through each test phase. Configuration writes never share a cycle with a message, so no property has to handle a filter that changes while it is being compared.

// File: rtl/canAcceptPkg.sv
package canAcceptPkg;
  localparam int ID_W   = 29;
  localparam int STD_W  = 11;
  localparam int DATA_W = 16;
  localparam int KEY_W  = ID_W + DATA_W;
  localparam int CFG_W  = KEY_W + 1;

  typedef struct packed {
    logic wrEn;
    logic rdEn;
  } ctlStrobe_t;

  typedef struct packed {
    logic              ide;
    logic [ID_W-1:0]   id;
    logic [DATA_W-1:0] data;
  } fifoEntry_t;
endpackage

// File: rtl/canAcceptDatapath.sv
module canAcceptDatapath
  import canAcceptPkg::*;
#(
  parameter int NUM_FILT = 8,
  parameter int DEPTH    = 8,
  localparam int SEL_W   = $clog2(NUM_FILT),
  localparam int HIT_W   = SEL_W + 1,
  localparam int PTR_W   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWrite,
  input  logic [SEL_W-1:0]  cfgSel,
  input  logic              cfgIsMask,
  input  logic [CFG_W-1:0]  cfgValue,
  input  logic [ID_W-1:0]   msgId,
  input  logic              msgIde,
  input  logic [7:0]        msgData0,
  input  logic [7:0]        msgData1,
  input  logic              filtEnable,
  input  ctlStrobe_t        strobe,
  input  logic [PTR_W-1:0]  wrPtr,
  input  logic [PTR_W-1:0]  rdPtr,
  output logic              anyHit,
  output logic [HIT_W-1:0]  lastHit,
  output logic [ID_W-1:0]   rdId,
  output logic              rdIde,
  output logic [7:0]        rdData0,
  output logic [7:0]        rdData1,
  output logic [HIT_W-1:0]  rdHit
);
  logic [ID_W-1:0]   keyId;
  logic [KEY_W-1:0]  msgKey;
  logic [NUM_FILT-1:0] match;
  logic [SEL_W-1:0]  winIdx;
  logic [HIT_W-1:0]  curHit;

  // Standard identifiers are left-aligned; the low extended bits compare as zero
  assign keyId  = msgIde ? msgId : {msgId[STD_W-1:0], {(ID_W-STD_W){1'b0}}};
  assign msgKey = {keyId, msgData0, msgData1};

  for (genvar f = 0; f < NUM_FILT; f++) begin : g_filt
    logic [CFG_W-1:0] fVal;
    logic [KEY_W-1:0] mVal;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        fVal <= '0;
        mVal <= '0;
      end else if (cfgWrite && cfgSel == SEL_W'(f)) begin
        if (cfgIsMask) mVal <= cfgValue[KEY_W-1:0];
        else           fVal <= cfgValue;
      end
    end

    assign match[f] = (fVal[KEY_W] == msgIde) &&
                      (((fVal[KEY_W-1:0] ^ msgKey) & mVal) == '0);
  end

  // Lowest-numbered matching filter wins
  always_comb begin
    winIdx = '0;
    for (int i = NUM_FILT - 1; i >= 0; i--) begin
      if (match[i]) winIdx = SEL_W'(i);
    end
  end

  assign anyHit = |match;
  assign curHit = (filtEnable && anyHit) ? {1'b1, winIdx} : '0;

  fifoEntry_t       mem    [DEPTH];
  logic [HIT_W-1:0] hitMem [DEPTH];

  always_ff @(posedge clk) begin
    if (strobe.wrEn) begin
      mem[wrPtr]    <= '{ide: msgIde, id: msgId, data: {msgData0, msgData1}};
      hitMem[wrPtr] <= curHit;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            lastHit <= '0;
    else if (strobe.wrEn) lastHit <= curHit;
  end

  fifoEntry_t headEntry;
  assign headEntry = mem[rdPtr];
  assign rdId    = headEntry.id;
  assign rdIde   = headEntry.ide;
  assign rdData0 = headEntry.data[15:8];
  assign rdData1 = headEntry.data[7:0];
  assign rdHit   = hitMem[rdPtr];
endmodule

// File: rtl/canAcceptControl.sv
module canAcceptControl
  import canAcceptPkg::*;
#(
  parameter int DEPTH    = 8,
  localparam int PTR_W   = $clog2(DEPTH),
  localparam int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             msgValid,
  input  logic             filtEnable,
  input  logic             anyHit,
  input  logic             popReq,
  output ctlStrobe_t       strobe,
  output logic [PTR_W-1:0] wrPtr,
  output logic [PTR_W-1:0] rdPtr,
  output logic [CNT_W-1:0] fifoCount,
  output logic             fifoFull,
  output logic             fifoEmpty,
  output logic             overflowFlag,
  output logic             pushStrobe
);
  logic passes;

  assign fifoFull  = (fifoCount == CNT_W'(DEPTH));
  assign fifoEmpty = (fifoCount == '0);
  assign passes    = msgValid && (!filtEnable || anyHit);

  always_comb begin
    strobe.wrEn = passes && !fifoFull;
    strobe.rdEn = popReq && !fifoEmpty;
  end

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr        <= '0;
      rdPtr        <= '0;
      fifoCount    <= '0;
      overflowFlag <= 1'b0;
      pushStrobe   <= 1'b0;
    end else begin
      pushStrobe <= strobe.wrEn;
      if (strobe.wrEn) wrPtr <= bump(wrPtr);
      if (strobe.rdEn) rdPtr <= bump(rdPtr);
      if (strobe.wrEn && !strobe.rdEn)      fifoCount <= fifoCount + 1'b1;
      else if (strobe.rdEn && !strobe.wrEn) fifoCount <= fifoCount - 1'b1;
      if (passes && fifoFull) overflowFlag <= 1'b1;
    end
  end
endmodule

// File: rtl/canAcceptBank.sv
module canAcceptBank
  import canAcceptPkg::*;
#(
  parameter int NUM_FILT = 8,
  parameter int DEPTH    = 8,
  localparam int SEL_W   = $clog2(NUM_FILT),
  localparam int HIT_W   = SEL_W + 1,
  localparam int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             msgValid,
  input  logic [ID_W-1:0]  msgId,
  input  logic             msgIde,
  input  logic [7:0]       msgData0,
  input  logic [7:0]       msgData1,
  input  logic             filtEnable,
  input  logic             cfgWrite,
  input  logic [SEL_W-1:0] cfgSel,
  input  logic             cfgIsMask,
  input  logic [CFG_W-1:0] cfgValue,
  input  logic             popReq,
  output logic             pushStrobe,
  output logic [HIT_W-1:0] hitCode,
  output logic [CNT_W-1:0] fifoCount,
  output logic             fifoFull,
  output logic             fifoEmpty,
  output logic             overflowFlag,
  output logic [ID_W-1:0]  rdId,
  output logic             rdIde,
  output logic [7:0]       rdData0,
  output logic [7:0]       rdData1,
  output logic [HIT_W-1:0] rdHit
);
  localparam int PTR_W = $clog2(DEPTH);

  ctlStrobe_t       strobe;
  logic             anyHit;
  logic [PTR_W-1:0] wrPtr, rdPtr;

  canAcceptControl #(.DEPTH(DEPTH)) u_ctl (
    .clk(clk), .rstN(rstN), .msgValid(msgValid), .filtEnable(filtEnable),
    .anyHit(anyHit), .popReq(popReq), .strobe(strobe), .wrPtr(wrPtr),
    .rdPtr(rdPtr), .fifoCount(fifoCount), .fifoFull(fifoFull),
    .fifoEmpty(fifoEmpty), .overflowFlag(overflowFlag), .pushStrobe(pushStrobe)
  );

  canAcceptDatapath #(.NUM_FILT(NUM_FILT), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .cfgWrite(cfgWrite), .cfgSel(cfgSel),
    .cfgIsMask(cfgIsMask), .cfgValue(cfgValue), .msgId(msgId), .msgIde(msgIde),
    .msgData0(msgData0), .msgData1(msgData1), .filtEnable(filtEnable),
    .strobe(strobe), .wrPtr(wrPtr), .rdPtr(rdPtr), .anyHit(anyHit),
    .lastHit(hitCode), .rdId(rdId), .rdIde(rdIde), .rdData0(rdData0),
    .rdData1(rdData1), .rdHit(rdHit)
  );
endmodule

// File: rtl/canAcceptChecker.sv
module canAcceptChecker #(
  parameter int DEPTH = 8,
  parameter int HIT_W = 4,
  parameter int CNT_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             msgValid,
  input logic             filtEnable,
  input logic             popReq,
  input logic             pushStrobe,
  input logic [HIT_W-1:0] hitCode,
  input logic [CNT_W-1:0] fifoCount,
  input logic             fifoFull,
  input logic             fifoEmpty,
  input logic             overflowFlag
);
  // R7
  count_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoCount <= CNT_W'(DEPTH));

  // R7
  full_not_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoFull |-> !fifoEmpty);

  // R8
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    overflowFlag |=> overflowFlag);

  // R8
  full_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && fifoFull && !filtEnable) |=> (!pushStrobe && overflowFlag));

  // R9
  push_needs_msg_chk: assert property (@(posedge clk) disable iff (!rstN)
    !msgValid |=> !pushStrobe);

  // R4
  accept_all_chk: assert property (@(posedge clk) disable iff (!rstN)
    (msgValid && !filtEnable && !fifoFull) |=> (pushStrobe && hitCode == '0));

  // R10
  empty_pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (popReq && fifoEmpty && !msgValid) |=> fifoEmpty);
endmodule

bind canAcceptBank canAcceptChecker #(.DEPTH(DEPTH), .HIT_W(HIT_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rstN(rstN), .msgValid(msgValid), .filtEnable(filtEnable),
  .popReq(popReq), .pushStrobe(pushStrobe), .hitCode(hitCode),
  .fifoCount(fifoCount), .fifoFull(fifoFull), .fifoEmpty(fifoEmpty),
  .overflowFlag(overflowFlag)
);

// File: tb/canAcceptBank_tb.sv
module canAcceptBank_tb;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rstN = 1'b0;
  logic        msgValid = 0, msgIde = 0, filtEnable = 0;
  logic [28:0] msgId = '0;
  logic [7:0]  msgData0 = '0, msgData1 = '0;
  logic        cfgWrite = 0, cfgIsMask = 0, popReq = 0;
  logic [2:0]  cfgSel = '0;
  logic [45:0] cfgValue = '0;
  logic        pushStrobe, fifoFull, fifoEmpty, overflowFlag, rdIde;
  logic [3:0]  hitCode, fifoCount, rdHit;
  logic [28:0] rdId;
  logic [7:0]  rdData0, rdData1;

  canAcceptBank u_dut (.*);

  int nChecks = 0, nFails = 0;
  bit finished = 0;

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wrCfg(input int sel, input bit isMask, input logic [45:0] v);
    @(negedge clk);
    cfgWrite = 1; cfgSel = 3'(sel); cfgIsMask = isMask; cfgValue = v;
    @(negedge clk);
    cfgWrite = 0;
  endtask

  task automatic send(input logic [28:0] id, input bit ide, input logic [7:0] d0, input logic [7:0] d1);
    @(negedge clk);
    msgValid = 1; msgId = id; msgIde = ide; msgData0 = d0; msgData1 = d1;
    @(negedge clk);
    msgValid = 0;
  endtask

  task automatic sendVec(input logic [44:0] v, input bit ide);
    send(v[44:16], ide, v[15:8], v[7:0]);
  endtask

  task automatic popOne();
    @(negedge clk);
    popReq = 1;
    @(negedge clk);
    popReq = 0;
  endtask

  task automatic drain();
    for (int k = 0; k < 9 && !fifoEmpty; k++) popOne();
  endtask

  localparam logic [45:0] FULL_MASK = {1'b0, {45{1'b1}}};

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 empty", fifoEmpty, 1);
    check("R1 count", fifoCount, 0);
    check("R1 full", fifoFull, 0);
    check("R1 overflow", overflowFlag, 0);
    check("R1 push", pushStrobe, 0);

    // R10 pop while empty
    popOne();
    check("R10 count", fifoCount, 0);
    check("R10 empty", fifoEmpty, 1);

    // R6/R7/R5: each filter with full mask and distinct key
    filtEnable = 1;
    for (int n = 0; n < 8; n++) begin
      wrCfg(n, 1, FULL_MASK);
      wrCfg(n, 0, {1'b1, 29'h0123_4000 + 29'(n * 77), 8'(n), 8'(~n)});
    end
    for (int n = 0; n < 8; n++) begin
      send(29'h0123_4000 + 29'(n * 77), 1, 8'(n), 8'(~n));
      check("R6 push", pushStrobe, 1);
      check("R6 hit code", hitCode, 64'(8 + n));
      check("R7 head id", rdId, 64'(29'h0123_4000 + 29'(n * 77)));
      check("R7 head data", {rdIde, rdData0, rdData1}, {1'b1, 8'(n), 8'(~n)});
      check("R7 head hit", rdHit, 64'(8 + n));
      popOne();
      send(29'h0123_4000 + 29'(n * 77), 1, 8'(n), 8'(n));
      check("R5 no push", pushStrobe, 0);
      check("R5 count", fifoCount, 0);
    end

    // R2 single-bit mask sweep over the whole key
    for (int n = 1; n < 8; n++) wrCfg(n, 0, 46'h0);
    for (int b = 0; b < 45; b++) begin
      logic [44:0] bitv, noise;
      bitv  = 45'd1 << b;
      noise = {3{15'h5a3c}} ^ 45'(b * 911);
      wrCfg(0, 1, {1'b0, bitv});
      wrCfg(0, 0, {1'b1, bitv});
      sendVec(noise | bitv, 1);
      check("R2 masked bit equal", pushStrobe, 1);
      check("R2 hit", hitCode, 8);
      popOne();
      sendVec(noise & ~bitv, 1);
      check("R2 masked bit differs", pushStrobe, 0);
    end

    // R3 standard identifier alignment and format flag
    wrCfg(0, 1, {1'b0, {29{1'b1}}, 16'h0});
    wrCfg(0, 0, {1'b0, 11'h5A3, 18'h0, 16'h0});
    send({18'h3FFFF, 11'h5A3}, 0, 8'hAB, 8'hCD);
    check("R3 std accept", pushStrobe, 1);
    check("R3 std hit", hitCode, 8);
    check("R3 head raw id", rdId, 64'({18'h3FFFF, 11'h5A3}));
    popOne();
    send({18'h0, 11'h5A2}, 0, 8'hAB, 8'hCD);
    check("R3 std miss", pushStrobe, 0);
    send({11'h5A3, 18'h0}, 1, 8'hAB, 8'hCD);
    check("R3 format mismatch", pushStrobe, 0);
    wrCfg(0, 0, {1'b0, 11'h5A3, 18'h1, 16'h0});
    send({18'h0, 11'h5A3}, 0, 8'h00, 8'h00);
    check("R3 low bits as zero", pushStrobe, 0);

    // R6 lowest matching filter wins
    wrCfg(5, 1, 46'h0);
    wrCfg(5, 0, {1'b1, 45'h0});
    send(29'h1ABCDEF0, 1, 8'h11, 8'h22);
    check("R6 filter5", hitCode, 4'b1101);
    popOne();
    wrCfg(3, 1, 46'h0);
    wrCfg(3, 0, {1'b1, 45'h0});
    send(29'h00000001, 1, 8'h33, 8'h44);
    check("R6 filter3 beats 5", hitCode, 4'b1011);
    popOne();
    wrCfg(7, 1, 46'h0);
    wrCfg(7, 0, {1'b1, 45'h0});
    send(29'h0FFFFFFF, 1, 8'h55, 8'h66);
    check("R6 filter3 beats 7", hitCode, 4'b1011);
    popOne();

    // R4 filtering off accepts everything with code 0
    filtEnable = 0;
    send(29'h7FF, 0, 8'h01, 8'h02);
    check("R4 std accept", pushStrobe, 1);
    check("R4 code", hitCode, 0);
    popOne();
    send(29'h1234567, 1, 8'h03, 8'h04);
    check("R4 ext accept", pushStrobe, 1);
    check("R4 head hit", rdHit, 0);
    popOne();

    // R8/R9/R7 fill, overflow, order
    for (int i = 0; i < 8; i++) begin
      send(29'(i + 100), 1, 8'(i), 8'(i));
      check("R9 single push", pushStrobe, 1);
    end
    @(negedge clk);
    check("R9 strobe one cycle", pushStrobe, 0);
    check("R7 full", fifoFull, 1);
    check("R7 count 8", fifoCount, 8);
    send(29'd999, 1, 8'h0, 8'h0);
    check("R8 drop push", pushStrobe, 0);
    check("R8 overflow", overflowFlag, 1);
    check("R8 count", fifoCount, 8);
    @(negedge clk);
    msgValid = 1; popReq = 1; msgId = 29'd998;
    @(negedge clk);
    msgValid = 0; popReq = 0;
    check("R8 drop with pop", pushStrobe, 0);
    check("R8 count after pop", fifoCount, 7);
    for (int i = 1; i < 8; i++) begin
      check("R7 order", rdId, 64'(i + 100));
      popOne();
    end
    check("R7 drained", fifoEmpty, 1);
    check("R8 sticky", overflowFlag, 1);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end
endmodule